// File: doc/BRIEF.md
# Bus-Activity Watchdog with Port Shutdown

This block guards a set of powered ports against a host that has stopped talking. It watches the raw clock line of a two-wire serial bus, brings that line into the system clock domain, and treats every transition of it, rising or falling, as a sign of life. When the line stays still for a programmable number of system clock cycles (nominally two seconds), the watchdog expires.

Expiry always raises a sticky status flag. Unless a 4-bit disable code in the control byte holds the value `1011`, expiry also asks for every port to be switched off. In the same cycle it pulses a strobe that wipes the per-port event, status and enable bits held elsewhere. It reports which ports actually changed power state and passes on the updated power-enable and power-good status with the affected ports forced off. The counter parks at expiry, so one quiet period produces one shutdown. Only a new bus clock transition re-arms it.

The control/status byte is written through a simple write port and is always visible on a read-data output. The bus slave, the port power stages and the other register banks sit outside this block.

Top module: `bus_watchdog_shutdown`

## Requirements
- R1: While reset is asserted, the control byte reads `0x16`: disable code `1011` in bits 4:1, status flag bit 0 clear, bits 7:5 zero. All strobe and change outputs are 0, and the power-status outputs are 0.
- R2: Any transition of the bus clock line, rising or falling, restarts the quiet count. Transitions spaced exactly LIMIT system clock cycles apart never cause an expiry.
- R3: After the last bus clock transition, applied between two system clock edges, expiry takes effect on the (LIMIT+3)th following rising edge. The status flag (bit 0) and any shutdown strobes become visible after that edge, and not before.
- R4: Once expired, the counter holds and no further expiry occurs until a new bus clock transition. A quiet period of any length gives exactly one one-cycle strobe.
- R5: Expiry sets the status flag whatever the disable code holds.
- R6: Writing a byte with bit 0 = 0 clears the status flag, and writing bit 0 = 1 leaves it unchanged. If a clearing write lands on the expiry edge, the flag ends up set.
- R7: A write loads bits 4:1 into the disable code, and bits 7:5 always read as 0. The disable code in force before an edge decides that edge's action. Code `1011` suppresses all shutdown outputs, and each of the other 15 codes lets them act.
- R8: An unmasked expiry drives `ports_off_o` and `evt_clear_o` high for exactly one cycle.
- R9: On an unmasked expiry, `en_chg_set_o[i]` equals `pwr_en_i[i]` and `good_chg_set_o[i]` equals `pwr_good_i[i]`, both sampled at the expiry edge. At all other times these outputs are 0.
- R10: `pwr_en_o` and `pwr_good_o` follow `pwr_en_i` and `pwr_good_i` one cycle late, and are all 0 in the cycle that follows an unmasked expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Raw bus clock line, asynchronous |
| cfg_wr_en | input | 1 | Write strobe for the control byte |
| cfg_wr_data | input | 8 | Write data: bits 4:1 disable code, bit 0 status write |
| cfg_rd_data | output | 8 | Current control byte |
| pwr_en_i | input | NUM_PORTS | Current power-enable state per port |
| pwr_good_i | input | NUM_PORTS | Current power-good state per port |
| ports_off_o | output | 1 | One-cycle request to switch all ports off |
| evt_clear_o | output | 1 | One-cycle strobe clearing per-port event, status and enable bits |
| en_chg_set_o | output | NUM_PORTS | Set pulses for power-enable change flags |
| good_chg_set_o | output | NUM_PORTS | Set pulses for power-good change flags |
| pwr_en_o | output | NUM_PORTS | Updated power-enable status |
| pwr_good_o | output | NUM_PORTS | Updated power-good status |

## Verification
Two things can land on the same rising edge: a register write and the watchdog expiry. A clearing write meets the flag's own set, and a new disable code meets the decision to shut down. The bench provokes both by placing a write exactly on the expiry edge. It expects the flag to read back as set and the shutdown to follow the code in force before the edge. The same quiet-period run is repeated for all sixteen disable codes, and the bench judges each against an arithmetic model of the byte and the per-port flags.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    localparam int          CTRL_W    = 8;
    localparam int          DIS_W     = 4;
    localparam int          DIS_LSB   = 1;
    localparam int          FLAG_BIT  = 0;
    localparam logic [3:0]  MASK_CODE = 4'b1011;

    typedef struct packed {
        logic [DIS_W-1:0] dis;
        logic             flag;
    } ctrl_t;
endpackage

// File: rtl/bwd_scl_sync.sv
module bwd_scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic kick_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    if (STAGES < 2) begin : g_bad_stages
        $error("bwd_scl_sync needs at least two stages");
    end

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], scl_i};
        st_d.last  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign kick_o = st_q.chain[STAGES-1] ^ st_q.last;

    // R2
    edge_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> (st_q.last != $past(st_q.last)));
endmodule

// File: rtl/bwd_timeout.sv
module bwd_timeout #(
    parameter int LIMIT = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic expire_o
);
    localparam int             CW     = $clog2(LIMIT + 1);
    localparam logic [CW-1:0]  LIM_C  = CW'(LIMIT);
    localparam logic [CW-1:0]  LIM_M1 = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmo_state_t;

    tmo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kick_i)               st_d.cnt = '0;
        else if (st_q.cnt != LIM_C) st_d.cnt = st_q.cnt + 1'b1;
        expire_o = !kick_i && (st_q.cnt == LIM_M1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> (st_q.cnt == '0));
    // R4
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);
    // R4
    parked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == LIM_C && !kick_i) |=> (st_q.cnt == LIM_C));
endmodule

// File: rtl/bwd_ctrl_reg.sv
module bwd_ctrl_reg
    import bwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    input  logic              set_i,
    output logic [CTRL_W-1:0] rd_data_o,
    output logic              masked_o
);
    ctrl_t st_d, st_q;
    logic  unused_hi;

    assign unused_hi = ^wr_data_i[CTRL_W-1:DIS_LSB+DIS_W];

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.dis = wr_data_i[DIS_LSB +: DIS_W];
            if (!wr_data_i[FLAG_BIT]) st_d.flag = 1'b0;
        end
        if (set_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dis  <= MASK_CODE;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = {{(CTRL_W-DIS_W-1){1'b0}}, st_q.dis, st_q.flag};
    assign masked_o  = (st_q.dis == MASK_CODE);

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.flag);
    // R6
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[FLAG_BIT] && !set_i) |=> (st_q.flag == $past(st_q.flag)));
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[FLAG_BIT] && !set_i) |=> !st_q.flag);
    // R7
    dis_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (st_q.dis == $past(wr_data_i[DIS_LSB +: DIS_W])));
endmodule

// File: rtl/bwd_shutdown.sv
module bwd_shutdown #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 expire_i,
    input  logic                 masked_i,
    input  logic [NUM_PORTS-1:0] en_cur_i,
    input  logic [NUM_PORTS-1:0] good_cur_i,
    output logic                 off_o,
    output logic                 clr_o,
    output logic [NUM_PORTS-1:0] en_set_o,
    output logic [NUM_PORTS-1:0] good_set_o,
    output logic [NUM_PORTS-1:0] en_upd_o,
    output logic [NUM_PORTS-1:0] good_upd_o
);
    typedef struct packed {
        logic                 off;
        logic                 clr;
        logic [NUM_PORTS-1:0] en_set;
        logic [NUM_PORTS-1:0] good_set;
        logic [NUM_PORTS-1:0] en_upd;
        logic [NUM_PORTS-1:0] good_upd;
    } sd_state_t;

    sd_state_t st_d, st_q;
    logic      fire;

    always_comb begin
        fire = expire_i && !masked_i;
        st_d = st_q;
        st_d.off = fire;
        st_d.clr = fire;
        for (int i = 0; i < NUM_PORTS; i++) begin
            st_d.en_set[i]   = fire & en_cur_i[i];
            st_d.good_set[i] = fire & good_cur_i[i];
            st_d.en_upd[i]   = ~fire & en_cur_i[i];
            st_d.good_upd[i] = ~fire & good_cur_i[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_o      = st_q.off;
    assign clr_o      = st_q.clr;
    assign en_set_o   = st_q.en_set;
    assign good_set_o = st_q.good_set;
    assign en_upd_o   = st_q.en_upd;
    assign good_upd_o = st_q.good_upd;

    // R8
    one_cycle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_o |=> !off_o);
    // R7
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && masked_i) |=> (!off_o && !clr_o));
    // R9
    chg_only_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_set_o | good_set_o) != '0) |-> off_o);
    // R10
    status_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        off_o |-> ((en_upd_o | good_upd_o) == '0));
endmodule

// File: rtl/bus_watchdog_shutdown.sv
module bus_watchdog_shutdown
    import bwd_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int LIMIT       = 250_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 cfg_wr_en,
    input  logic [7:0]           cfg_wr_data,
    output logic [7:0]           cfg_rd_data,
    input  logic [NUM_PORTS-1:0] pwr_en_i,
    input  logic [NUM_PORTS-1:0] pwr_good_i,
    output logic                 ports_off_o,
    output logic                 evt_clear_o,
    output logic [NUM_PORTS-1:0] en_chg_set_o,
    output logic [NUM_PORTS-1:0] good_chg_set_o,
    output logic [NUM_PORTS-1:0] pwr_en_o,
    output logic [NUM_PORTS-1:0] pwr_good_o
);
    logic kick;
    logic expire;
    logic masked;

    bwd_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl_i),
        .kick_o (kick)
    );

    bwd_timeout #(.LIMIT(LIMIT)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick_i   (kick),
        .expire_o (expire)
    );

    bwd_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cfg_wr_en),
        .wr_data_i (cfg_wr_data),
        .set_i     (expire),
        .rd_data_o (cfg_rd_data),
        .masked_o  (masked)
    );

    bwd_shutdown #(.NUM_PORTS(NUM_PORTS)) u_sd (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire_i   (expire),
        .masked_i   (masked),
        .en_cur_i   (pwr_en_i),
        .good_cur_i (pwr_good_i),
        .off_o      (ports_off_o),
        .clr_o      (evt_clear_o),
        .en_set_o   (en_chg_set_o),
        .good_set_o (good_chg_set_o),
        .en_upd_o   (pwr_en_o),
        .good_upd_o (pwr_good_o)
    );

    // R8
    strobes_paired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ports_off_o == evt_clear_o);
    // R5
    flag_with_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ports_off_o |-> cfg_rd_data[FLAG_BIT]);
endmodule

// File: tb/bus_watchdog_shutdown_tb.sv
`timescale 1ns/1ps
module bus_watchdog_shutdown_tb;
    localparam int NP = 4;
    localparam int T  = 12;
    localparam logic [3:0] MASK = 4'b1011;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scl;
    logic          wr_en;
    logic [7:0]    wr_data;
    logic [7:0]    rd_data;
    logic [NP-1:0] en_cur, good_cur;
    logic          ports_off, evt_clear;
    logic [NP-1:0] en_chg, good_chg, en_out, good_out;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [3:0] m_dis;
    logic       m_flag;

    always #4 clk = ~clk;

    bus_watchdog_shutdown #(.NUM_PORTS(NP), .LIMIT(T), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl),
        .cfg_wr_en(wr_en), .cfg_wr_data(wr_data), .cfg_rd_data(rd_data),
        .pwr_en_i(en_cur), .pwr_good_i(good_cur),
        .ports_off_o(ports_off), .evt_clear_o(evt_clear),
        .en_chg_set_o(en_chg), .good_chg_set_o(good_chg),
        .pwr_en_o(en_out), .pwr_good_o(good_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a negedge. Toggles the bus clock, then follows len posedges,
    // optionally presenting a write on posedge wr_at.
    task automatic window(input int len, input int wr_at, input logic [7:0] wb);
        scl = ~scl;
        for (int k = 1; k <= len; k++) begin
            bit fire;
            wr_en   = (k == wr_at);
            wr_data = wb;
            @(negedge clk);
            fire = (k == T + 3) && (m_dis != MASK);
            if (k == T + 3)                     m_flag = 1'b1;
            else if (k == wr_at && !wb[0])      m_flag = 1'b0;
            if (k == wr_at)                     m_dis  = wb[4:1];
            chk("R3 R6 R7 control byte", int'(rd_data), int'({3'b000, m_dis, m_flag}));
            chk("R8 R4 ports_off", int'(ports_off), int'(fire));
            chk("R8 evt_clear", int'(evt_clear), int'(fire));
            chk("R9 en change", int'(en_chg), fire ? int'(en_cur) : 0);
            chk("R9 good change", int'(good_chg), fire ? int'(good_cur) : 0);
            chk("R10 pwr_en", int'(en_out), fire ? 0 : int'(en_cur));
            chk("R10 pwr_good", int'(good_out), fire ? 0 : int'(good_cur));
        end
        wr_en = 1'b0;
    endtask

    // R2: toggles spaced exactly T cycles never expire.
    task automatic toggle_train(input int n);
        for (int j = 0; j < n; j++) begin
            scl = ~scl;
            for (int k = 0; k < T; k++) begin
                @(negedge clk);
                chk("R2 no expiry on edge train", int'(ports_off), 0);
                chk("R2 flag unchanged", int'(rd_data), int'({3'b000, m_dis, m_flag}));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; scl = 1'b0; wr_en = 1'b0; wr_data = '0;
        en_cur = '0; good_cur = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset byte", int'(rd_data), 8'h16);
        chk("R1 reset ports_off", int'(ports_off), 0);
        chk("R1 reset evt_clear", int'(evt_clear), 0);
        chk("R1 reset change flags", int'({en_chg, good_chg}), 0);
        chk("R1 reset status", int'({en_out, good_out}), 0);
        rst_n  = 1'b1;
        m_dis  = MASK;
        m_flag = 1'b0;

        // R5: masked expiry from a quiet line right after reset.
        for (int k = 1; k <= T + 4; k++) begin
            @(negedge clk);
            chk("R5 masked expiry no shutdown", int'(ports_off), 0);
        end
        m_flag = 1'b1;
        chk("R5 flag set while masked", int'(rd_data), 8'h17);

        // Clear flag at k=2, masked expiry sets it again.
        en_cur = 4'b1111; good_cur = 4'b0101;
        window(T + 6, 2, 8'h16);

        // Sweep all 16 disable codes.
        for (int c = 0; c < 16; c++) begin
            en_cur   = 4'(c) ^ 4'b0110;
            good_cur = 4'(c * 3);
            window(T + 6, 1, {3'b000, 4'(c), 1'b0});
        end

        // Write on the expiry edge: clear loses to set, old code decides (R6, R7).
        en_cur = 4'b1010; good_cur = 4'b1000;
        window(T + 6, T + 3, {3'b000, 4'b0000, 1'b0});
        window(T + 6, T + 3, {3'b000, MASK, 1'b0});
        // Code now 1011: write active code with bit0=1, flag kept; long quiet (R4).
        en_cur = 4'b0111; good_cur = 4'b0011;
        window(3 * T, 1, {3'b000, 4'b0001, 1'b1});
        // Bits 7:5 ignored (R7).
        window(T + 6, 1, 8'hFF);

        // Edge train then one more quiet period (R2, R3).
        toggle_train(6);
        en_cur = 4'b1100; good_cur = 4'b0100;
        window(T + 6, 1, 8'h02);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule